// File: doc/BRIEF.md
# Consecutive-Cycle Digital Lock Detector

This block watches the up and down pulses of a phase-frequency detector and decides whether the loop has settled. A fast timing clock counts the ticks in each reference window during which either pulse is high. That count is the window's phase error. A strobe marks the start of each reference window, and the window just closed is judged in the strobe cycle.

A window with a small error is good. A window with a large error, or a pulse still high when the next strobe arrives, is bad. A window between the two thresholds is in between. The active-high lock flag rises after a run of consecutive good windows. A select input sets the run length to three or five windows. Once the flag is set, only a single bad window clears it. The gap between the set threshold and the clear threshold gives the flag hysteresis.

The controller has two states. ST_SEEK means unlocked and counting the good run. ST_LOCKED means the flag is raised. ST_SEEK moves to ST_LOCKED on the good window that completes the run. ST_SEEK stays in ST_SEEK, and clears the run, on any window that is not good. ST_LOCKED moves to ST_SEEK on a bad window. ST_LOCKED stays in ST_LOCKED on good and in-between windows.

Top module: `phase_lock_monitor`

## Requirements
- R1: `lock_o` is active high. It is 0 during reset and right after reset. Reset also empties the good-run count, so a run that was partly built before reset does not count afterwards.
- R2: A window covers the strobe cycle and every cycle up to the one before the next strobe. Its error is the number of timing-clock cycles in the window during which `up_i` or `dn_i` is high. Both pulses count the same way.
- R3: A window is good when its error is strictly below `set_ticks` and it did not overrun. With `sel_five`=0, the third consecutive good window sets `lock_o` in the cycle after that window's closing strobe.
- R4: With `sel_five`=1, five consecutive good windows are needed before `lock_o` is set.
- R5: While unlocked, any window whose error is `set_ticks` or more, or that overran, resets the good run to zero.
- R6: While locked, a window whose error is strictly above `clr_ticks` clears `lock_o` in the cycle after its closing strobe.
- R7: While locked, a window whose error lies from `set_ticks` to `clr_ticks`, both included, leaves `lock_o` high.
- R8: If `up_i` or `dn_i` is high in a strobe cycle, the window that strobe closes counts as bad.
- R9: `lock_o` changes only in the cycle that follows a strobe, or at reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock that measures pulse widths |
| rst_n | input | 1 | Asynchronous reset, active low |
| up_i | input | 1 | Up pulse from the phase detector |
| dn_i | input | 1 | Down pulse from the phase detector |
| ref_stb | input | 1 | One-cycle strobe that opens a new reference window |
| sel_five | input | 1 | Run length select: 0 needs three good windows, 1 needs five |
| set_ticks | input | TICK_W | An error below this many ticks makes a window good |
| clr_ticks | input | TICK_W | An error above this many ticks makes a window bad |
| lock_o | output | 1 | Lock flag, active high |

## Verification
In a strobe cycle, two things happen at once. The window that just ended is judged, and the new window starts counting any pulse that is already high. An overrun window makes both happen in the same cycle: the pulse is held through the strobe. The bench then checks that the closed window is judged bad. It also checks that the next window's error includes the carried tick, through the good or not-good outcome the model predicts for it. A second case that falls in one cycle is the good window that completes the run. In that cycle the run counter clears while the state moves to locked. The run then starts over after the next bad window, and the bench checks that a full new run is needed before the flag rises again.

// File: rtl/lockdet_pkg.sv
package lockdet_pkg;

    typedef enum logic [1:0] {
        VERD_GOOD = 2'd0,
        VERD_MID  = 2'd1,
        VERD_BAD  = 2'd2
    } verdict_e;

    typedef enum logic {
        ST_SEEK   = 1'b0,
        ST_LOCKED = 1'b1
    } lock_state_e;

endpackage

// File: rtl/lockdet_phase_meter.sv
module lockdet_phase_meter
    import lockdet_pkg::*;
#(
    parameter int TICK_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              up_i,
    input  logic              dn_i,
    input  logic              ref_stb,
    input  logic [TICK_W-1:0] set_ticks,
    input  logic [TICK_W-1:0] clr_ticks,
    output logic [TICK_W-1:0] err_ticks,
    output verdict_e          verdict
);

    localparam logic [TICK_W-1:0] TICK_MAX = {TICK_W{1'b1}};
    localparam logic [TICK_W-1:0] TICK_ONE = {{(TICK_W-1){1'b0}}, 1'b1};

    logic pulse_on;
    logic overrun;

    assign pulse_on = up_i | dn_i;
    // A pulse still high in the strobe cycle did not end inside the old window
    assign overrun  = ref_stb & pulse_on;

    // Tick counter for the open window; saturates instead of wrapping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_ticks <= '0;
        end else if (ref_stb) begin
            err_ticks <= pulse_on ? TICK_ONE : '0;
        end else if (pulse_on && (err_ticks != TICK_MAX)) begin
            err_ticks <= err_ticks + TICK_ONE;
        end
    end

    // Judgement of the window being closed (meaningful when ref_stb is high)
    always_comb begin
        if (overrun || (err_ticks > clr_ticks)) begin
            verdict = VERD_BAD;
        end else if (err_ticks < set_ticks) begin
            verdict = VERD_GOOD;
        end else begin
            verdict = VERD_MID;
        end
    end

endmodule

// File: rtl/lockdet_run_counter.sv
module lockdet_run_counter #(
    parameter int RUN_SHORT = 3,
    parameter int RUN_LONG  = 5,
    parameter int RUN_W     = $clog2(RUN_LONG + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_long,
    input  logic             run_clr,
    input  logic             run_inc,
    output logic [RUN_W-1:0] run_cnt,
    output logic             run_hit
);

    localparam logic [RUN_W:0] NEED_SHORT = RUN_SHORT[RUN_W:0];
    localparam logic [RUN_W:0] NEED_LONG  = RUN_LONG[RUN_W:0];

    logic [RUN_W:0] run_next;
    logic [RUN_W:0] need;

    assign need     = sel_long ? NEED_LONG : NEED_SHORT;
    assign run_next = {1'b0, run_cnt} + 1'b1;
    // The good window now being judged would complete the run
    assign run_hit  = (run_next >= need);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_cnt <= '0;
        end else if (run_clr) begin
            run_cnt <= '0;
        end else if (run_inc) begin
            run_cnt <= run_next[RUN_W-1:0];
        end
    end

endmodule

// File: rtl/lockdet_fsm.sv
module lockdet_fsm
    import lockdet_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     ref_stb,
    input  verdict_e verdict,
    input  logic     run_hit,
    output logic     lock_o,
    output logic     run_inc,
    output logic     run_clr
);

    lock_state_e state_q;
    lock_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_SEEK;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SEEK: begin
                if (ref_stb && (verdict == VERD_GOOD) && run_hit) begin
                    state_d = ST_LOCKED;
                end
            end
            ST_LOCKED: begin
                if (ref_stb && (verdict == VERD_BAD)) begin
                    state_d = ST_SEEK;
                end
            end
            default: state_d = ST_SEEK;
        endcase
    end

    always_comb begin
        lock_o  = 1'b0;
        run_inc = 1'b0;
        run_clr = 1'b0;
        unique case (state_q)
            ST_SEEK: begin
                if (ref_stb) begin
                    if ((verdict == VERD_GOOD) && !run_hit) begin
                        run_inc = 1'b1;
                    end else begin
                        run_clr = 1'b1;
                    end
                end
            end
            ST_LOCKED: begin
                lock_o  = 1'b1;
                run_clr = 1'b1;
            end
            default: run_clr = 1'b1;
        endcase
    end

endmodule

// File: rtl/phase_lock_monitor.sv
module phase_lock_monitor
    import lockdet_pkg::*;
#(
    parameter int TICK_W    = 8,
    parameter int RUN_SHORT = 3,
    parameter int RUN_LONG  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              up_i,
    input  logic              dn_i,
    input  logic              ref_stb,
    input  logic              sel_five,
    input  logic [TICK_W-1:0] set_ticks,
    input  logic [TICK_W-1:0] clr_ticks,
    output logic              lock_o
);

    localparam int RUN_W = $clog2(RUN_LONG + 1);

    logic [TICK_W-1:0] err_ticks;
    verdict_e          verdict;
    logic [RUN_W-1:0]  run_cnt;
    logic              run_hit;
    logic              run_inc;
    logic              run_clr;

    lockdet_phase_meter #(
        .TICK_W(TICK_W)
    ) i_meter (
        .clk      (clk),
        .rst_n    (rst_n),
        .up_i     (up_i),
        .dn_i     (dn_i),
        .ref_stb  (ref_stb),
        .set_ticks(set_ticks),
        .clr_ticks(clr_ticks),
        .err_ticks(err_ticks),
        .verdict  (verdict)
    );

    lockdet_run_counter #(
        .RUN_SHORT(RUN_SHORT),
        .RUN_LONG (RUN_LONG),
        .RUN_W    (RUN_W)
    ) i_run (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_long(sel_five),
        .run_clr (run_clr),
        .run_inc (run_inc),
        .run_cnt (run_cnt),
        .run_hit (run_hit)
    );

    lockdet_fsm i_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .ref_stb(ref_stb),
        .verdict(verdict),
        .run_hit(run_hit),
        .lock_o (lock_o),
        .run_inc(run_inc),
        .run_clr(run_clr)
    );

endmodule

// File: rtl/phase_lock_monitor_chk.sv
module phase_lock_monitor_chk
    import lockdet_pkg::*;
#(
    parameter int TICK_W   = 8,
    parameter int RUN_LONG = 5,
    parameter int RUN_W    = $clog2(RUN_LONG + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              up_i,
    input logic              dn_i,
    input logic              ref_stb,
    input logic [TICK_W-1:0] clr_ticks,
    input logic [TICK_W-1:0] err_ticks,
    input verdict_e          verdict,
    input logic [RUN_W-1:0]  run_cnt,
    input logic              lock_o
);

    localparam logic [RUN_W-1:0] RUN_TOP = RUN_LONG[RUN_W-1:0];

    // R9: the flag only moves on a window boundary
    a_r9_lock_moves_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_stb |=> $stable(lock_o));

    // R6 and R8: a bad window drops the flag
    a_r6_drop_on_bad: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_o && ref_stb && (up_i || dn_i || (err_ticks > clr_ticks))) |=> !lock_o);

    // R7: an error that is not above the clear threshold keeps the flag
    a_r7_hold_in_band: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_o && ref_stb && !(up_i || dn_i) && (err_ticks <= clr_ticks)) |=> lock_o);

    // R3: the flag rises only after a good window
    a_r3_rise_after_good: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_o) |-> $past(ref_stb && (verdict == VERD_GOOD)));

    // R5: a window that is not good empties the run while unlocked
    a_r5_run_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (!lock_o && ref_stb && (verdict != VERD_GOOD)) |=> (run_cnt == '0));

    // R4: the run never passes the longest length
    a_r4_run_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        run_cnt <= RUN_TOP);

    // R1: a raised flag leaves no partial run behind
    a_r1_locked_run_empty: assert property (@(posedge clk) disable iff (!rst_n)
        lock_o |-> (run_cnt == '0));

endmodule

bind phase_lock_monitor phase_lock_monitor_chk #(
    .TICK_W  (TICK_W),
    .RUN_LONG(RUN_LONG)
) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .up_i     (up_i),
    .dn_i     (dn_i),
    .ref_stb  (ref_stb),
    .clr_ticks(clr_ticks),
    .err_ticks(err_ticks),
    .verdict  (verdict),
    .run_cnt  (run_cnt),
    .lock_o   (lock_o)
);

// File: tb/test_phase_lock_monitor.sv
module test_phase_lock_monitor;

    localparam int TICK_W = 8;
    localparam int WIN    = 24;
    localparam int SET_T  = 6;
    localparam int CLR_T  = 10;

    typedef struct {
        bit    val;
        string tag;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              up_i = 1'b0;
    logic              dn_i = 1'b0;
    logic              ref_stb = 1'b0;
    logic              sel_five = 1'b0;
    logic [TICK_W-1:0] set_ticks = TICK_W'(SET_T);
    logic [TICK_W-1:0] clr_ticks = TICK_W'(CLR_T);
    logic              lock_o;

    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;
    exp_t q[$];
    bit   exp_cur = 1'b0;
    bit   m_lock = 1'b0;
    int   m_run = 0;
    bit   m_carry = 1'b0;

    always #10 clk = ~clk;

    phase_lock_monitor #(.TICK_W(TICK_W)) i_phase_lock_monitor (
        .clk      (clk),
        .rst_n    (rst_n),
        .up_i     (up_i),
        .dn_i     (dn_i),
        .ref_stb  (ref_stb),
        .sel_five (sel_five),
        .set_ticks(set_ticks),
        .clr_ticks(clr_ticks),
        .lock_o   (lock_o)
    );

    task automatic check(string tag, bit act, bit exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: lock_o=%0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        up_i = 1'b0;
        dn_i = 1'b0;
        ref_stb = 1'b0;
        q.delete();
        exp_cur = 1'b0;
        m_lock = 1'b0;
        m_run = 0;
        m_carry = 1'b0;
        @(negedge clk);
        check("R1 during reset", lock_o, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", lock_o, 1'b0);
    endtask

    // One window: w pulse ticks (on dn when use_dn), then the closing strobe.
    // With ovr the pulse stays high through the strobe cycle.
    task automatic window(int w, bit ovr, bit use_dn, string tag);
        int   err;
        bit   good;
        bit   bad;
        exp_t e;
        for (int i = 0; i < WIN - 1; i++) begin
            @(negedge clk);
            ref_stb = 1'b0;
            up_i = (ovr || (i < w)) && !use_dn;
            dn_i = (ovr || (i < w)) && use_dn;
        end
        @(negedge clk);
        ref_stb = 1'b1;
        up_i = ovr && !use_dn;
        dn_i = ovr && use_dn;
        err  = (ovr ? (WIN - 1) : w) + (m_carry ? 1 : 0);
        good = !ovr && (err < SET_T);
        bad  = ovr || (err > CLR_T);
        if (!m_lock) begin
            if (good) begin
                m_run++;
                if (m_run >= (sel_five ? 5 : 3)) begin
                    m_lock = 1'b1;
                    m_run = 0;
                end
            end else begin
                m_run = 0;
            end
        end else if (bad) begin
            m_lock = 1'b0;
        end
        m_carry = ovr;
        e.val = m_lock;
        e.tag = tag;
        q.push_back(e);
    endtask

    // Monitor: compare after each rising edge
    always begin
        bit   stb;
        bit   rs;
        exp_t e;
        @(posedge clk);
        stb = ref_stb;
        rs = rst_n;
        #2;
        if (rs && rst_n && !done) begin
            if (stb) begin
                if (q.size() == 0) begin
                    errors++;
                    checks++;
                    $display("FAIL R9: strobe with no expected item, lock_o=%0d expected none", lock_o);
                end else begin
                    e = q.pop_front();
                    exp_cur = e.val;
                    check(e.tag, lock_o, e.val);
                end
            end else begin
                check("R9 between strobes", lock_o, exp_cur);
            end
        end
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: run did not end, actual hung expected finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R3: three good windows with the short run
        window(2, 0, 0, "R3 good 1 of 3");
        window(0, 0, 1, "R3 good 2 of 3");
        window(5, 0, 0, "R3 good 3 of 3 locks");
        // R7: errors in the band keep the flag
        window(8, 0, 1, "R7 mid error holds");
        window(6, 0, 0, "R7 error at set threshold holds");
        window(10, 0, 0, "R7 error at clear threshold holds");
        window(2, 0, 0, "R7 good while locked holds");
        // R6: one tick over the clear threshold drops it
        window(11, 0, 1, "R6 error above clear drops");
        // R5: a window at the set threshold restarts the run
        window(2, 0, 0, "R5 run 1");
        window(2, 0, 0, "R5 run 2");
        window(6, 0, 0, "R5 error at set threshold clears run");
        window(2, 0, 0, "R5 restart 1");
        window(2, 0, 0, "R5 restart 2");
        window(2, 0, 1, "R5 restart 3 locks");
        // R8: a pulse held through the strobe is bad, and carries a tick
        window(0, 1, 0, "R8 overrun drops lock");
        window(4, 0, 0, "R2 carried tick counted (err 5 good)");
        window(5, 0, 0, "R2 err 5 good run 2");
        window(5, 0, 1, "R2 err 5 good run 3 locks");
        window(0, 1, 1, "R8 overrun on dn drops lock");
        window(5, 0, 0, "R2 carried tick makes err 6 not good");
        // R4: long run needs five good windows
        sel_five = 1'b1;
        window(1, 0, 0, "R4 good 1 of 5");
        window(1, 0, 1, "R4 good 2 of 5");
        window(1, 0, 0, "R4 good 3 of 5");
        window(1, 0, 0, "R4 good 4 of 5");
        window(1, 0, 0, "R4 good 5 of 5 locks");
        window(12, 0, 0, "R6 drop in long mode");
        // R1: reset empties a partial run
        sel_five = 1'b0;
        window(1, 0, 0, "R1 run 1 before reset");
        window(1, 0, 0, "R1 run 2 before reset");
        do_reset();
        window(1, 0, 0, "R1 run restarts after reset 1");
        window(1, 0, 0, "R1 run restarts after reset 2");
        window(1, 0, 0, "R1 run restarts after reset 3 locks");
        // R1: reset clears a raised flag
        do_reset();
        @(negedge clk);
        ref_stb = 1'b0;
        repeat (4) @(negedge clk);
        done = 1'b1;
        if (q.size() != 0) begin
            errors++;
            checks++;
            $display("FAIL R9: %0d expected items left, expected 0", q.size());
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule